// File: doc/BRIEF.md
# Two-Output Interrupt Router

The block collects twenty-six interrupt request lines and drives two requests toward a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Sources 0 to 5 arrive from package pins with no timing relation to the clock. Sources 6 to 25 come from on-chip peripherals that already run on the block's clock. Each source has its own detection mode (level or rising edge), its own mask bit and its own choice of output.

Software uses a small write/read register port. Three configuration words hold detection mode, mask and output routing, each with one bit per source. A read-only word shows pending status. A write-only word clears latched edge events, one bit per source. Bit `i` of every word belongs to source `i`.

The block has no control state machine. Its sequential state is the pin synchronizer chain, one previous-value flop and one edge latch per source, the three configuration words, and the two output flops.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset, MODE (address 0) reads 0, MASK (address 1) reads all ones, ROUTE (address 2) reads 0, and `irq_o` and `fiq_o` are low. While every mask bit is 1, both outputs stay low.
- R2: An external source (bits 0 to 5) passes through two clocked stages before detection. After a pin change it appears in PENDING after the second clock edge, and reaches an output after the third edge.
- R3: In level mode (MODE bit = 0), the PENDING bit (address 3) equals the current synchronized input, with nothing latched. Internal sources (bits 6 to 25) are seen without delay.
- R4: In edge mode (MODE bit = 1), a 0-to-1 change of the synchronized input sets the pending bit. The bit stays set after the input falls, until a write to CLEAR (address 4) puts 1 in that bit. Zero bits in a CLEAR write change nothing. A new edge in the same cycle as a clear leaves the bit set.
- R5: Setting a source back to level mode discards its latched edge. A later return to edge mode does not bring the old event back.
- R6: One clock edge after any source is pending, unmasked (MASK bit = 0) and routed to IRQ (ROUTE bit = 0), `irq_o` is high. It is low one edge after no such source exists.
- R7: `fiq_o` follows the rule of R6 for sources with ROUTE bit = 1. A source routed to FIQ never raises `irq_o`.
- R8: A masked source still records and shows its pending bit. Unmasking it raises the routed output on the next edge.
- R9: Addresses 5 to 7 read 0, and writes to them are ignored. CLEAR reads 0. Writes to PENDING change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 6 | Asynchronous external request pins, sources 0 to 5 |
| int_irq_i | input | 20 | Synchronous internal request lines, sources 6 to 25 |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 26 | Register write data, one bit per source |
| cfg_rdata_o | output | 26 | Register read data, combinational from the address |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
Some rules are checked by assertions on every cycle:
- the synchronizer output equals the pin value from two edges earlier;
- a latched edge survives any cycle with no clear;
- no latch survives a cycle spent in level mode;
- full masking keeps both outputs quiet;
- the clear word reads zero.

The scenarios and the cycle-by-cycle reference model cover the rest. That includes the exact latency differences between pin and internal sources, clears with mixed bit patterns, the loss of an event when its mode is toggled, deferred delivery after unmasking, and the address decode under random traffic.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        SEL_MODE  = 3'd0,
        SEL_MASK  = 3'd1,
        SEL_ROUTE = 3'd2,
        SEL_PEND  = 3'd3,
        SEL_CLEAR = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];

    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               warm_q <= '0;
        else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_chk2
            // R2: output is the pin value from two edges earlier
            a_r2_two_stage_lag: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q >= 2'd2) |-> (sync_o == $past(async_i, 2)));
        end
    endgenerate
endmodule

// File: rtl/irq_detect.sv
`timescale 1ns/1ps
module irq_detect #(
    parameter int unsigned N = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] mode_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= level_i;
            latch_q <= mode_i & ((latch_q & ~clr_i) | (level_i & ~prev_q));
        end
    end

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_src
            assign pend_o[i] = mode_i[i] ? latch_q[i] : level_i[i];
        end
    endgenerate

    // R4: a latched event in edge mode stays until cleared
    a_r4_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((latch_q & $past(mode_i & latch_q & ~clr_i)) == $past(mode_i & latch_q & ~clr_i)));

    // R5: nothing stays latched past a cycle in level mode
    a_r5_level_drops: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((latch_q & ~$past(mode_i)) == '0));
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
    import irq_pkg::*;
#(
    parameter int unsigned N = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    input  logic [N-1:0]      pend_i,
    output logic [N-1:0]      rdata_o,
    output logic [N-1:0]      mode_o,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      route_o,
    output logic [N-1:0]      clr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o  <= '0;
            mask_o  <= '1;
            route_o <= '0;
        end else if (we_i) begin
            case (addr_i)
                SEL_MODE:  mode_o  <= wdata_i;
                SEL_MASK:  mask_o  <= wdata_i;
                SEL_ROUTE: route_o <= wdata_i;
                default:   ;
            endcase
        end
    end

    assign clr_o = (we_i && addr_i == SEL_CLEAR) ? wdata_i : '0;

    always_comb begin
        case (addr_i)
            SEL_MODE:  rdata_o = mode_o;
            SEL_MASK:  rdata_o = mask_o;
            SEL_ROUTE: rdata_o = route_o;
            SEL_PEND:  rdata_o = pend_i;
            default:   rdata_o = '0;
        endcase
    end

    // R9: the clear word is write-only
    a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == SEL_CLEAR) |-> (rdata_o == '0));
endmodule

// File: rtl/irq_fiq_ctrl.sv
`timescale 1ns/1ps
module irq_fiq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned N_EXT       = 6,
    parameter int unsigned N_INT       = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_EXT-1:0]       ext_irq_i,
    input  logic [N_INT-1:0]       int_irq_i,
    input  logic                   cfg_we_i,
    input  logic [REG_AW-1:0]      cfg_addr_i,
    input  logic [N_EXT+N_INT-1:0] cfg_wdata_i,
    output logic [N_EXT+N_INT-1:0] cfg_rdata_o,
    output logic                   irq_o,
    output logic                   fiq_o
);
    localparam int unsigned N_SRC = N_EXT + N_INT;

    logic [N_EXT-1:0] ext_sync;
    logic [N_SRC-1:0] level, pend, mode, mask, route, clr;

    irq_sync #(.WIDTH(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_irq_i), .sync_o(ext_sync));

    assign level = {int_irq_i, ext_sync};

    irq_detect #(.N(N_SRC)) u_detect (
        .clk(clk), .rst_n(rst_n), .level_i(level), .mode_i(mode),
        .clr_i(clr), .pend_o(pend));

    irq_regs #(.N(N_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .pend_i(pend), .rdata_o(cfg_rdata_o),
        .mode_o(mode), .mask_o(mask), .route_o(route), .clr_o(clr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(pend & ~mask & ~route);
            fiq_o <= |(pend & ~mask & route);
        end
    end

    // R1: a fully masked controller raises nothing
    a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |=> (!irq_o && !fiq_o));

    // R7: sources all routed to FIQ never raise the normal request
    a_r7_fiq_only: assert property (@(posedge clk) disable iff (!rst_n)
        (&route) |=> !irq_o);
endmodule

// File: tb/irq_fiq_ctrl_test.sv
`timescale 1ns/1ps
module irq_fiq_ctrl_test;
    localparam int NS = 26;
    localparam logic [NS-1:0] ALL = {NS{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    ext_irq = '0;
    logic [19:0]   int_irq = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [NS-1:0] cfg_wdata = '0;
    logic [NS-1:0] cfg_rdata;
    logic          irq_o, fiq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_fiq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .int_irq_i(int_irq),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .cfg_rdata_o(cfg_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

    // behavioural reference model
    logic [NS-1:0] m_mode, m_mask, m_route, m_latch, m_prev;
    logic          m_irq, m_fiq;
    logic [5:0]    ext_pipe[$];

    function automatic logic [5:0] m_ext_seen();
        return (ext_pipe.size() == 2) ? ext_pipe[0] : 6'd0;
    endfunction

    function automatic logic [NS-1:0] m_pend();
        logic [NS-1:0] cur;
        cur = {int_irq, m_ext_seen()};
        return (m_mode & m_latch) | (~m_mode & cur);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = '0; m_mask = ALL; m_route = '0;
            m_latch = '0; m_prev = '0; m_irq = 0; m_fiq = 0;
            ext_pipe.delete();
        end else begin
            logic [NS-1:0] cur, p, clrv;
            cur  = {int_irq, m_ext_seen()};
            p    = m_pend();
            m_irq = |(p & ~m_mask & ~m_route);
            m_fiq = |(p & ~m_mask & m_route);
            clrv = (cfg_we && cfg_addr == 3'd4) ? cfg_wdata : '0;
            for (int i = 0; i < NS; i++) begin
                if (!m_mode[i])                m_latch[i] = 1'b0;
                else if (cur[i] && !m_prev[i]) m_latch[i] = 1'b1;
                else if (clrv[i])              m_latch[i] = 1'b0;
            end
            m_prev = cur;
            ext_pipe.push_back(ext_irq);
            if (ext_pipe.size() > 2) void'(ext_pipe.pop_front());
            if (cfg_we) begin
                if (cfg_addr == 3'd0) m_mode  = cfg_wdata;
                if (cfg_addr == 3'd1) m_mask  = cfg_wdata;
                if (cfg_addr == 3'd2) m_route = cfg_wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [NS-1:0] got, input logic [NS-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NS-1:0] er;
            case (cfg_addr)
                3'd0: er = m_mode;
                3'd1: er = m_mask;
                3'd2: er = m_route;
                3'd3: er = m_pend();
                default: er = '0;
            endcase
            chk("R6 irq_o vs model", {25'd0, irq_o}, {25'd0, m_irq});
            chk("R7 fiq_o vs model", {25'd0, fiq_o}, {25'd0, m_fiq});
            chk("R3 read data vs model", cfg_rdata, er);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [NS-1:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 0; cfg_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [NS-1:0] exp);
        cfg_addr = a;
        #0.5;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic outs(input string tag, input logic ei, input logic ef);
        chk(tag, {24'd0, irq_o, fiq_o}, {24'd0, ei, ef});
    endtask

    localparam logic [NS-1:0] B2 = 26'd1 << 2;
    localparam logic [NS-1:0] B7 = 26'd1 << 7;
    localparam logic [NS-1:0] B10 = 26'd1 << 10;
    localparam logic [NS-1:0] B15 = 26'd1 << 15;
    localparam logic [NS-1:0] B20 = 26'd1 << 20;

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset values
        outs("R1 outputs after reset", 0, 0);
        rd("R1 mode reset", 3'd0, '0);
        rd("R1 mask reset", 3'd1, ALL);
        rd("R1 route reset", 3'd2, '0);
        int_irq[4] = 1;
        tick();
        outs("R1 masked source stays quiet", 0, 0);
        int_irq[4] = 0;
        tick();

        // R3 / R6 internal level source 10
        wr(3'd1, '0);
        int_irq[4] = 1;
        tick();
        rd("R3 internal level pending", 3'd3, B10);
        outs("R6 irq after one edge", 1, 0);
        int_irq[4] = 0;
        tick();
        rd("R3 level not latched", 3'd3, '0);
        outs("R6 irq drops", 0, 0);

        // R2 external source 2
        ext_irq[2] = 1;
        tick();
        rd("R2 not yet after first edge", 3'd3, '0);
        tick();
        rd("R2 pending after second edge", 3'd3, B2);
        outs("R2 output not yet", 0, 0);
        tick();
        outs("R2 output after third edge", 1, 0);
        ext_irq[2] = 0;
        repeat (3) tick();
        outs("R2 output released", 0, 0);

        // R4 / R7 edge source 15 routed to FIQ
        wr(3'd0, B15);
        wr(3'd2, B15);
        int_irq[9] = 1;
        tick();
        int_irq[9] = 0;
        tick();
        rd("R4 edge latched", 3'd3, B15);
        outs("R7 fiq raised, irq not", 0, 1);
        wr(3'd4, ALL & ~B15);
        rd("R4 zero clear bits ignored", 3'd3, B15);
        wr(3'd4, B15);
        rd("R4 cleared by one", 3'd3, '0);
        tick();
        outs("R7 fiq released", 0, 0);
        // R4 edge together with clear keeps the bit
        int_irq[9] = 1;
        cfg_we = 1; cfg_addr = 3'd4; cfg_wdata = B15;
        tick();
        cfg_we = 0; cfg_wdata = '0; int_irq[9] = 0;
        rd("R4 edge wins over clear", 3'd3, B15);
        wr(3'd4, B15);
        wr(3'd2, '0);
        wr(3'd0, '0);

        // R5 mode change discards latch, source 20
        wr(3'd0, B20);
        int_irq[14] = 1;
        tick();
        int_irq[14] = 0;
        tick();
        rd("R5 latched before switch", 3'd3, B20);
        wr(3'd0, '0);
        rd("R5 level shows input", 3'd3, '0);
        tick();
        wr(3'd0, B20);
        rd("R5 old event gone", 3'd3, '0);
        wr(3'd0, '0);

        // R8 masked edge source 7
        wr(3'd0, B7);
        wr(3'd1, B7);
        int_irq[1] = 1;
        tick();
        int_irq[1] = 0;
        tick();
        rd("R8 masked still pending", 3'd3, B7);
        outs("R8 masked output quiet", 0, 0);
        wr(3'd1, '0);
        tick();
        outs("R8 unmask raises irq", 1, 0);
        wr(3'd4, B7);
        tick();
        outs("R8 cleared output", 0, 0);
        wr(3'd0, '0);

        // R9 address decode
        wr(3'd6, ALL);
        wr(3'd5, ALL);
        wr(3'd3, ALL);
        rd("R9 mode untouched", 3'd0, '0);
        rd("R9 mask untouched", 3'd1, '0);
        rd("R9 route untouched", 3'd2, '0);
        rd("R9 pend untouched", 3'd3, '0);
        rd("R9 addr5 zero", 3'd5, '0);
        rd("R9 addr6 zero", 3'd6, '0);
        rd("R9 addr7 zero", 3'd7, '0);
        rd("R9 clear reads zero", 3'd4, '0);

        // random traffic against the model
        for (int k = 0; k < 2000; k++) begin
            for (int b = 0; b < 6; b++)
                if ($urandom_range(0, 7) == 0) ext_irq[b] = ~ext_irq[b];
            for (int b = 0; b < 20; b++)
                if ($urandom_range(0, 7) == 0) int_irq[b] = ~int_irq[b];
            cfg_we    = ($urandom_range(0, 5) == 0);
            cfg_addr  = 3'($urandom_range(0, 7));
            cfg_wdata = NS'($urandom());
            tick();
        end
        cfg_we = 0;
        tick();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule